// File: doc/BRIEF.md
# Two-Wire Serial Slave Front End for a Digital Potentiometer

This block is the bus-facing half of a digitally controlled potentiometer. It watches an oversampled two-wire bus (clock and data lines brought in as plain inputs), recognises start and stop conditions, and frames the serial stream into bytes. The first byte after a start names the device. Its upper four bits must carry a fixed device type and the next three must match three strap pins. The last bit selects a write or a read. A write continues with a command byte and at most one data byte. A read streams bytes supplied by the register controller until the master declines one.

The block does not interpret commands. It hands each accepted byte to a register controller as a one-cycle strobe with a tag saying whether the byte was the identification, the command or the data byte. It also passes one-cycle start and stop strobes and a load strobe for read data. The controller raises `nv_busy` while an internal nonvolatile write runs. During that time the block refuses to acknowledge even its own address, so a master can poll for completion by sending the address again until it is acknowledged. The data line is only ever pulled low, through an active-low enable that the pad turns into an open-drain driver.

Top module: `dpot_twi_slave`

## Requirements
- R1: While reset is high and on the first cycle after it, `sda_pull_n` is 1 and `byte_valid`, `start_seen`, `stop_seen` and `rd_load` are 0.
- R2: `start_seen` pulses for one cycle when data falls while the clock is high. `stop_seen` pulses for one cycle when data rises while the clock is high. Data changes made while the clock is low produce neither strobe.
- R3: Until the first start condition, clock and data activity is ignored. No byte strobe is produced and `sda_pull_n` stays 1.
- R4: The identification byte is taken MSB first, with bits sampled on clock rising edges. Bits 7..4 must equal 4'b0101 and bits 3..1 must equal `addr_pins[2:0]`. On a match the slave pulls data low for the whole ninth clock and strobes `byte_valid` with `byte_index` = 2'b00 and `rx_byte` = the byte. On a mismatch there is no acknowledge and no strobe for any byte until the next start.
- R5: If `nv_busy` is 1 when the eighth identification bit is sampled, a matching address is neither acknowledged nor strobed. Once `nv_busy` is 0, the same address is acknowledged again.
- R6: With bit 0 of the identification byte at 0 (write), the next byte is acknowledged and strobed with `byte_index` = 2'b01 (command). The byte after it is acknowledged and strobed with `byte_index` = 2'b10 (data). Any further byte is neither acknowledged nor strobed.
- R7: With bit 0 at 1 (read), `rd_data` is captured at the falling edge that ends each acknowledge clock, and `rd_load` pulses. The byte is shifted out MSB first, changing only while the clock is low. Data is released for the master's acknowledge clock. A master acknowledge (low) loads the next byte. A not-acknowledge (high) ends the read, and the line stays released.
- R8: A repeated start in the middle of any byte resets bit counting, and the next eight bits are again treated as an identification byte.
- R9: A stop condition returns the slave to idle from any state with data released. Later clocking without a new start is ignored.
- R10: `sda_pull_n` changes only while the synchronised clock is low, except when it is released by a start or stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling system clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Bus clock line level |
| sda_in | input | 1 | Bus data line level (wired-AND of all drivers) |
| addr_pins | input | 3 | Strap pins giving the device's three address bits |
| nv_busy | input | 1 | Nonvolatile write in progress; blocks address acknowledge |
| rd_data | input | 8 | Byte to send on a read, sampled when `rd_load` is raised |
| sda_pull_n | output | 1 | Active-low data pull-down enable (open drain) |
| rx_byte | output | 8 | Last accepted received byte |
| byte_valid | output | 1 | One-cycle strobe: `rx_byte` and `byte_index` are new |
| byte_index | output | 2 | 00 identification, 01 command, 10 data |
| start_seen | output | 1 | One-cycle strobe on a start or repeated start |
| stop_seen | output | 1 | One-cycle strobe on a stop |
| rd_load | output | 1 | One-cycle strobe: `rd_data` was captured for sending |

## Verification
A bit counter that is off by one puts the acknowledge in the wrong clock, so the data line is seen low on a data bit or high on the ninth clock within the same byte. It also shifts every read bit by one position. A frame state that does not advance or does not reset shows at the next byte: an acknowledge appears where none is due, or is missing, and `byte_index` carries the wrong tag. Start and stop decoding errors appear as strobe counts that differ from the conditions the master made, three system clocks after the bus edge.

// File: rtl/dpot_twi_pkg.sv
package dpot_twi_pkg;

    localparam int TYPE_W = 4;
    localparam int ADDR_W = 3;
    localparam int BYTE_W = TYPE_W + ADDR_W + 1;
    localparam int CNT_W  = $clog2(BYTE_W + 2);

    localparam logic [TYPE_W-1:0] DEV_TYPE_DEFAULT = 4'b0101;

    // Role of the byte frame currently on the bus
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ID,
        ST_CMD,
        ST_DATA,
        ST_READ,
        ST_IGNORE
    } frame_e;

    // Tag handed to the register controller with each accepted byte
    typedef enum logic [1:0] {
        IDX_ID   = 2'b00,
        IDX_CMD  = 2'b01,
        IDX_DATA = 2'b10
    } byte_idx_e;

    // What the open-drain output is doing
    typedef enum logic [1:0] {
        DRV_REL,
        DRV_ACK,
        DRV_TX
    } drv_e;

    // Decoded bus events from the synchronised lines
    typedef struct packed {
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
        logic scl_lvl;
        logic sda_lvl;
    } bus_ev_t;

    function automatic logic id_hit(
        input logic [BYTE_W-1:0] b,
        input logic [TYPE_W-1:0] dev_type,
        input logic [ADDR_W-1:0] straps
    );
        return (b[BYTE_W-1 -: TYPE_W] == dev_type) && (b[1 +: ADDR_W] == straps);
    endfunction

endpackage

// File: rtl/dpot_twi_cond.sv
module dpot_twi_cond
    import dpot_twi_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_in,
    input  logic    sda_in,
    output bus_ev_t ev
);

    logic [SYNC_STAGES-1:0] scl_sy;
    logic [SYNC_STAGES-1:0] sda_sy;
    logic                   scl_q;
    logic                   sda_q;
    logic                   scl_s;
    logic                   sda_s;

    // Synchroniser chain; idle bus level is high
    generate
        for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
            always_ff @(posedge clk) begin
                if (rst) begin
                    scl_sy[i] <= 1'b1;
                    sda_sy[i] <= 1'b1;
                end else if (i == 0) begin
                    scl_sy[i] <= scl_in;
                    sda_sy[i] <= sda_in;
                end else begin
                    scl_sy[i] <= scl_sy[(i == 0) ? 0 : i-1];
                    sda_sy[i] <= sda_sy[(i == 0) ? 0 : i-1];
                end
            end
        end
    endgenerate

    assign scl_s = scl_sy[SYNC_STAGES-1];
    assign sda_s = sda_sy[SYNC_STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    always_comb begin
        ev.scl_rise = scl_s & ~scl_q;
        ev.scl_fall = ~scl_s & scl_q;
        ev.start    = scl_s & scl_q & sda_q & ~sda_s;
        ev.stop     = scl_s & scl_q & ~sda_q & sda_s;
        ev.scl_lvl  = scl_s;
        ev.sda_lvl  = sda_s;
    end

endmodule

// File: rtl/dpot_twi_txsh.sv
module dpot_twi_txsh
    import dpot_twi_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ld,
    input  logic              sh,
    input  logic [BYTE_W-1:0] din,
    output logic              msb
);

    logic [BYTE_W-1:0] sreg;

    always_ff @(posedge clk) begin
        if (rst) begin
            sreg <= '1;
        end else if (ld) begin
            sreg <= din;
        end else if (sh) begin
            sreg <= {sreg[BYTE_W-2:0], 1'b1};
        end
    end

    assign msb = sreg[BYTE_W-1];

endmodule

// File: rtl/dpot_twi_frame.sv
module dpot_twi_frame
    import dpot_twi_pkg::*;
#(
    parameter logic [TYPE_W-1:0] DEV_TYPE = DEV_TYPE_DEFAULT
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_ev_t           ev,
    input  logic [ADDR_W-1:0] addr_pins,
    input  logic              nv_busy,
    output frame_e            state,
    output drv_e              drv,
    output logic              ld,
    output logic              sh,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              byte_valid,
    output byte_idx_e         byte_index,
    output logic              start_seen,
    output logic              stop_seen,
    output logic              rd_load
);

    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);
    localparam logic [CNT_W-1:0] ACK_POS  = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] END_POS  = CNT_W'(BYTE_W + 1);

    logic [CNT_W-1:0]  cnt;
    logic [BYTE_W-2:0] rx_sh;
    logic [BYTE_W-1:0] full_b;
    logic              ack_ok;
    logic              rw;
    logic              mnack;
    logic              active;

    always_comb begin
        full_b = {rx_sh, ev.sda_lvl};
        active = (state != ST_IDLE) && (state != ST_IGNORE) && !ev.start && !ev.stop;
        ld     = active && ev.scl_fall && (cnt == END_POS) &&
                 (((state == ST_ID) && ack_ok && rw) || ((state == ST_READ) && !mnack));
        sh     = active && ev.scl_fall && (state == ST_READ) &&
                 (cnt != '0) && (cnt < ACK_POS);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            drv        <= DRV_REL;
            cnt        <= '0;
            rx_sh      <= '0;
            rx_byte    <= '0;
            byte_valid <= 1'b0;
            byte_index <= IDX_ID;
            start_seen <= 1'b0;
            stop_seen  <= 1'b0;
            rd_load    <= 1'b0;
            ack_ok     <= 1'b0;
            rw         <= 1'b0;
            mnack      <= 1'b0;
        end else begin
            byte_valid <= 1'b0;
            start_seen <= ev.start;
            stop_seen  <= ev.stop;
            rd_load    <= ld;
            if (ev.stop) begin
                state  <= ST_IDLE;
                cnt    <= '0;
                drv    <= DRV_REL;
                ack_ok <= 1'b0;
            end else if (ev.start) begin
                state  <= ST_ID;
                cnt    <= '0;
                drv    <= DRV_REL;
                ack_ok <= 1'b0;
                mnack  <= 1'b0;
            end else if (active) begin
                if (ev.scl_rise) begin
                    cnt <= cnt + 1'b1;
                    if (state != ST_READ) begin
                        if (cnt < ACK_POS) begin
                            rx_sh <= full_b[BYTE_W-2:0];
                        end
                        if (cnt == LAST_BIT) begin
                            unique case (state)
                                ST_ID: begin
                                    rw <= full_b[0];
                                    if (id_hit(full_b, DEV_TYPE, addr_pins) && !nv_busy) begin
                                        ack_ok     <= 1'b1;
                                        byte_valid <= 1'b1;
                                        byte_index <= IDX_ID;
                                        rx_byte    <= full_b;
                                    end
                                end
                                ST_CMD: begin
                                    ack_ok     <= 1'b1;
                                    byte_valid <= 1'b1;
                                    byte_index <= IDX_CMD;
                                    rx_byte    <= full_b;
                                end
                                ST_DATA: begin
                                    ack_ok     <= 1'b1;
                                    byte_valid <= 1'b1;
                                    byte_index <= IDX_DATA;
                                    rx_byte    <= full_b;
                                end
                                default: ;
                            endcase
                        end
                    end else if (cnt == ACK_POS) begin
                        mnack <= ev.sda_lvl;
                    end
                end else if (ev.scl_fall) begin
                    if (cnt == ACK_POS) begin
                        drv <= ((state != ST_READ) && ack_ok) ? DRV_ACK : DRV_REL;
                    end else if (cnt == END_POS) begin
                        cnt    <= '0;
                        ack_ok <= 1'b0;
                        drv    <= ld ? DRV_TX : DRV_REL;
                        unique case (state)
                            ST_ID:   state <= !ack_ok ? ST_IGNORE : (rw ? ST_READ : ST_CMD);
                            ST_CMD:  state <= ST_DATA;
                            ST_DATA: state <= ST_IGNORE;
                            ST_READ: if (mnack) state <= ST_IGNORE;
                            default: ;
                        endcase
                    end
                end
            end
        end
    end

endmodule

// File: rtl/dpot_twi_slave.sv
module dpot_twi_slave
    import dpot_twi_pkg::*;
#(
    parameter int                SYNC_STAGES = 2,
    parameter logic [TYPE_W-1:0] DEV_TYPE    = DEV_TYPE_DEFAULT
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_in,
    input  logic              sda_in,
    input  logic [ADDR_W-1:0] addr_pins,
    input  logic              nv_busy,
    input  logic [BYTE_W-1:0] rd_data,
    output logic              sda_pull_n,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              byte_valid,
    output logic [1:0]        byte_index,
    output logic              start_seen,
    output logic              stop_seen,
    output logic              rd_load
);

    bus_ev_t   ev;
    frame_e    fstate;
    drv_e      drv;
    byte_idx_e idx;
    logic      ld;
    logic      sh;
    logic      tx_msb;

    dpot_twi_cond #(.SYNC_STAGES(SYNC_STAGES)) u_cond (
        .clk    (clk),
        .rst    (rst),
        .scl_in (scl_in),
        .sda_in (sda_in),
        .ev     (ev)
    );

    dpot_twi_frame #(.DEV_TYPE(DEV_TYPE)) u_frame (
        .clk        (clk),
        .rst        (rst),
        .ev         (ev),
        .addr_pins  (addr_pins),
        .nv_busy    (nv_busy),
        .state      (fstate),
        .drv        (drv),
        .ld         (ld),
        .sh         (sh),
        .rx_byte    (rx_byte),
        .byte_valid (byte_valid),
        .byte_index (idx),
        .start_seen (start_seen),
        .stop_seen  (stop_seen),
        .rd_load    (rd_load)
    );

    dpot_twi_txsh u_txsh (
        .clk (clk),
        .rst (rst),
        .ld  (ld),
        .sh  (sh),
        .din (rd_data),
        .msb (tx_msb)
    );

    assign byte_index = idx;

    always_comb begin
        unique case (drv)
            DRV_ACK: sda_pull_n = 1'b0;
            DRV_TX:  sda_pull_n = tx_msb;
            default: sda_pull_n = 1'b1;
        endcase
    end

endmodule

// File: rtl/dpot_twi_chk.sv
module dpot_twi_chk
    import dpot_twi_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       scl_lvl,
    input logic       nv_busy,
    input frame_e     fstate,
    input logic       sda_pull_n,
    input logic       byte_valid,
    input logic [1:0] byte_index,
    input logic       start_seen,
    input logic       stop_seen,
    input logic       rd_load
);

    p_reset_quiet_r1: assert property (@(posedge clk)
        rst |=> (sda_pull_n && !byte_valid && !start_seen && !stop_seen && !rd_load));

    p_start_stop_excl_r2: assert property (@(posedge clk) disable iff (rst)
        !(start_seen && stop_seen));

    p_idle_released_r3: assert property (@(posedge clk) disable iff (rst)
        ((fstate == ST_IDLE) || (fstate == ST_IGNORE)) |-> sda_pull_n);

    p_strobe_gap_r4: assert property (@(posedge clk) disable iff (rst)
        byte_valid |=> !byte_valid);

    p_busy_noack_r5: assert property (@(posedge clk) disable iff (rst)
        (byte_valid && (byte_index == 2'b00)) |-> $past(!nv_busy));

    p_index_legal_r6: assert property (@(posedge clk) disable iff (rst)
        byte_valid |-> (byte_index != 2'b11));

    p_load_vs_strobe_r7: assert property (@(posedge clk) disable iff (rst)
        rd_load |-> !byte_valid);

    p_stop_release_r9: assert property (@(posedge clk) disable iff (rst)
        stop_seen |-> sda_pull_n);

    p_drive_scl_low_r10: assert property (@(posedge clk) disable iff (rst)
        ((sda_pull_n != $past(sda_pull_n)) && !start_seen && !stop_seen) |-> !scl_lvl);

endmodule

bind dpot_twi_slave dpot_twi_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .scl_lvl    (ev.scl_lvl),
    .nv_busy    (nv_busy),
    .fstate     (fstate),
    .sda_pull_n (sda_pull_n),
    .byte_valid (byte_valid),
    .byte_index (byte_index),
    .start_seen (start_seen),
    .stop_seen  (stop_seen),
    .rd_load    (rd_load)
);

// File: tb/dpot_twi_slave_bench.sv
module dpot_twi_slave_bench;

    localparam int H = 8;   // system clocks per bus half period
    localparam int NV = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic [2:0] addr_pins = 3'b101;
    logic       nv_busy = 1'b0;
    logic [7:0] rd_data = 8'h00;
    logic       sda_pull_n;
    logic [7:0] rx_byte;
    logic       byte_valid;
    logic [1:0] byte_index;
    logic       start_seen;
    logic       stop_seen;
    logic       rd_load;
    wire        sda_bus = sda_m & sda_pull_n;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    int         n_bv = 0, n_start = 0, n_stop = 0, n_ld = 0;
    logic [7:0] last_b = 8'h00;
    logic [1:0] last_i = 2'b11;

    always #2 clk = ~clk;   // 250 MHz

    dpot_twi_slave u_dpot_twi_slave (
        .clk        (clk),
        .rst        (rst),
        .scl_in     (scl_m),
        .sda_in     (sda_bus),
        .addr_pins  (addr_pins),
        .nv_busy    (nv_busy),
        .rd_data    (rd_data),
        .sda_pull_n (sda_pull_n),
        .rx_byte    (rx_byte),
        .byte_valid (byte_valid),
        .byte_index (byte_index),
        .start_seen (start_seen),
        .stop_seen  (stop_seen),
        .rd_load    (rd_load)
    );

    // Port monitor, sampled away from the active edge
    always @(negedge clk) begin
        if (!rst) begin
            if (byte_valid) begin
                n_bv++;
                last_b = rx_byte;
                last_i = byte_index;
            end
            if (start_seen) n_start++;
            if (stop_seen)  n_stop++;
            if (rd_load)    n_ld++;
        end
    end

    // {id[7:0], straps[2:0], busy, expect_ack}
    localparam logic [12:0] VEC [NV] = '{
        {8'h5A, 3'b101, 1'b0, 1'b1},
        {8'h50, 3'b000, 1'b0, 1'b1},
        {8'h5E, 3'b111, 1'b0, 1'b1},
        {8'h5A, 3'b100, 1'b0, 1'b0},
        {8'h7A, 3'b101, 1'b0, 1'b0},
        {8'h5A, 3'b101, 1'b1, 1'b0},
        {8'hDA, 3'b101, 1'b0, 1'b0},
        {8'h52, 3'b001, 1'b0, 1'b1}
    };

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic waitc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; waitc(H);
        scl_m = 1'b1; waitc(H);
        sda_m = 1'b0; waitc(H);
        scl_m = 1'b0; waitc(2);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; waitc(H);
        scl_m = 1'b1; waitc(H);
        sda_m = 1'b1; waitc(H);
    endtask

    task automatic send_bit(input logic b, output logic s);
        sda_m = b;    waitc(H);
        scl_m = 1'b1; waitc(H/2);
        s = sda_bus;  waitc(H/2);
        scl_m = 1'b0; waitc(2);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) send_bit(b[i], s);
        send_bit(1'b1, s);
        ack = !s;
    endtask

    task automatic read_byte(input logic mack, input logic [7:0] nxt, output logic [7:0] got);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            send_bit(1'b1, s);
            got[i] = s;
        end
        rd_data = nxt;
        send_bit(!mack, s);
    endtask

    initial begin
        logic       ack;
        logic       s;
        logic [7:0] got;
        int         bv0, st0, sp0, ld0;

        repeat (5) @(negedge clk);
        chk(sda_pull_n === 1'b1 && byte_valid === 1'b0, "R1 reset outputs", {sda_pull_n, byte_valid}, 2'b10);
        rst = 1'b0;
        @(negedge clk);
        chk(sda_pull_n === 1'b1 && !start_seen && !stop_seen && !rd_load, "R1 after reset",
            {sda_pull_n, start_seen, stop_seen, rd_load}, 4'b1000);

        // R3: matching byte clocked without a start
        scl_m = 1'b0; waitc(H);
        send_byte(8'h5A, ack);
        sda_m = 1'b1; waitc(H); scl_m = 1'b1; waitc(H);
        chk(!ack, "R3 no ack before start", ack, 0);
        chk(n_bv == 0, "R3 no strobe before start", n_bv, 0);
        chk(n_start == 0 && n_stop == 0, "R2 low-clock data edges make no condition", n_start + n_stop, 0);

        // R2 start and stop strobes
        bus_start();
        chk(n_start == 1, "R2 start strobe", n_start, 1);
        bus_stop();
        chk(n_stop == 1, "R2 stop strobe", n_stop, 1);

        // Table of identification cases (R4, R5)
        for (int v = 0; v < NV; v++) begin
            addr_pins = VEC[v][4:2];
            nv_busy   = VEC[v][1];
            bv0 = n_bv;
            bus_start();
            send_byte(VEC[v][12:5], ack);
            chk(ack == VEC[v][0], "R4/R5 address acknowledge", ack, VEC[v][0]);
            if (VEC[v][0])
                chk(last_b == VEC[v][12:5] && last_i == 2'b00, "R4 id strobe", {last_i, last_b}, {2'b00, VEC[v][12:5]});
            nv_busy = 1'b0;
            send_byte(8'h55, ack);
            chk(ack == VEC[v][0], "R4 follow byte ack after id", ack, VEC[v][0]);
            chk(n_bv - bv0 == (VEC[v][0] ? 2 : 0), "R4 strobe count", n_bv - bv0, VEC[v][0] ? 2 : 0);
            bus_stop();
        end

        // R5: polling until the write is done
        addr_pins = 3'b101;
        nv_busy = 1'b1;
        bus_start(); send_byte(8'h5A, ack); bus_stop();
        chk(!ack, "R5 busy poll refused", ack, 0);
        nv_busy = 1'b0;
        bus_start(); send_byte(8'h5A, ack); bus_stop();
        chk(ack, "R5 poll accepted after busy", ack, 1);

        // R6: write with command, data and an extra byte
        bv0 = n_bv;
        bus_start();
        send_byte(8'h5A, ack);
        send_byte(8'hA4, ack);
        chk(ack && last_i == 2'b01 && last_b == 8'hA4, "R6 command byte", {ack, last_i, last_b}, {1'b1, 2'b01, 8'hA4});
        send_byte(8'h3C, ack);
        chk(ack && last_i == 2'b10 && last_b == 8'h3C, "R6 data byte", {ack, last_i, last_b}, {1'b1, 2'b10, 8'h3C});
        send_byte(8'h11, ack);
        chk(!ack && n_bv - bv0 == 3, "R6 extra byte ignored", {ack, n_bv - bv0}, 3);
        bus_stop();

        // R7: read two bytes
        rd_data = 8'hC5;
        ld0 = n_ld;
        bus_start();
        send_byte(8'h5B, ack);
        chk(ack, "R7 read address ack", ack, 1);
        read_byte(1'b1, 8'h3A, got);
        chk(got == 8'hC5, "R7 first read byte", got, 8'hC5);
        read_byte(1'b0, 8'hFF, got);
        chk(got == 8'h3A, "R7 second read byte", got, 8'h3A);
        send_bit(1'b1, s);
        chk(s == 1'b1, "R7 released after master nack", s, 1);
        chk(n_ld - ld0 == 2, "R7 load strobes", n_ld - ld0, 2);
        bus_stop();

        // R8: repeated start in the middle of a command byte
        bus_start();
        send_byte(8'h5A, ack);
        send_bit(1'b0, s); send_bit(1'b1, s); send_bit(1'b1, s);
        st0 = n_start;
        bus_start();
        chk(n_start - st0 == 1, "R8 repeated start strobe", n_start - st0, 1);
        send_byte(8'h5A, ack);
        chk(ack && last_i == 2'b00, "R8 id after repeated start", {ack, last_i}, 3'b100);
        send_byte(8'h40, ack);
        chk(ack && last_i == 2'b01 && last_b == 8'h40, "R8 command after repeated start", {last_i, last_b}, {2'b01, 8'h40});
        bus_stop();

        // R9: stop in the middle of a byte, then clocking without start
        bus_start();
        send_byte(8'h5A, ack);
        send_bit(1'b1, s); send_bit(1'b0, s); send_bit(1'b1, s); send_bit(1'b0, s);
        sp0 = n_stop;
        bus_stop();
        chk(n_stop - sp0 == 1 && sda_pull_n, "R9 stop mid byte", {n_stop - sp0, sda_pull_n}, 3);
        bv0 = n_bv;
        scl_m = 1'b0; waitc(H);
        send_byte(8'h5A, ack);
        sda_m = 1'b1; waitc(H); scl_m = 1'b1; waitc(H);
        chk(!ack && n_bv == bv0, "R9 idle after stop", {ack, n_bv - bv0}, 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule